// File: doc/BRIEF.md
# Tunable NCO Quadrature Down-Mixer

This block turns a real, signed intermediate-frequency sample stream into a pair of baseband streams, in-phase (I) and quadrature (Q). A free-running 32-bit phase accumulator steps by a programmable tuning word on every clock. Its upper bits address a sine table. The cosine is read from the same table a quarter cycle ahead. Each accepted sample is multiplied by both waveforms, and each product is cut down to the output width with round-half-up, so that truncation adds no DC offset.

The tuning word sits in a control register that is written at run time through a small address/data/write-enable port. A new word changes the rate of the accumulator but never resets its phase, so a retune is phase-continuous. The frequency step is the clock rate divided by 2^32. To place the oscillator at frequency F, load round(F / step). The usable range runs from zero up to half the clock rate.

Top module: `nco_iq_mixer`

## Requirements
- R1: While reset is held, and in the first cycle after it, out_valid, out_i and out_q are 0. The tuning word and the accumulated phase both reset to 0.
- R2: A clock edge with cfg_we=1 and cfg_addr=0 loads cfg_wdata into the tuning word. A write to any other address leaves the tuning word unchanged.
- R3: The phase accumulator adds the tuning word on every clock edge, modulo 2^32, whether or not a sample is present. A sample accepted at an edge uses the accumulator value held before that edge's update.
- R4: The table index is the top 10 accumulator bits, k. sin(k) = round(32767·sin(2πk/1024)), rounded symmetrically about zero. cos(k) = sin((k+256) mod 1024).
- R5: out_i = (s·cos(k) + 2^13) >>> 14 and out_q = (s·sin(k) + 2^13) >>> 14, where s is the 14-bit signed sample and >>> is an arithmetic shift. This is round-half-up to 16 bits.
- R6: out_valid is in_valid delayed by exactly 3 clock edges. This holds for back-to-back samples and for samples with gaps.
- R7: A new tuning word takes effect from the edge after the write. The accumulator continues from its current phase and is not cleared.
- R8: Full-scale samples (-8192 and 8191) against full-scale table values give correctly rounded outputs without overflow or wrap.
- R9: With a tuning word of 0 the phase holds still. A constant input then gives constant I and Q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 14 | Signed IF sample |
| cfg_we | input | 1 | Control register write enable |
| cfg_addr | input | 2 | Control register address (0 = tuning word) |
| cfg_wdata | input | 32 | Control register write data |
| out_valid | output | 1 | I/Q strobe, 3 cycles after in_valid |
| out_i | output | 16 | Signed in-phase output |
| out_q | output | 16 | Signed quadrature output |

## Verification
The assertions check, on every cycle, these properties: writes to foreign addresses leave the tuning word alone, a tuning write lands with the written value, the table's quarter-cycle alignment at index 0 and its symmetric range, the absence of overflow in the rounding adder, and a zero sample giving a zero output one stage later. Only the bench's scenarios can show the rest, because it depends on accumulated history. That includes the exact table values across all 1024 indices, the phase continuity across a retune, the exact three-cycle strobe delay with gaps, and the rounding of full-scale products. The bench predicts all of these with an independent arithmetic model.

// File: rtl/nco_mix_pkg.sv
// Shared constants and elaboration-time helpers for the NCO down-mixer.
// Assumes: functions are only evaluated with constant arguments.
package nco_mix_pkg;

    localparam real PI_R = 3.14159265358979;

    // Rounded sine sample k of a quarter wave spanning `quarter` steps.
    function automatic int quarter_sine(int k, int quarter, int amp);
        real a;
        a = amp * $sin(2.0 * PI_R * k / (4.0 * quarter));
        return $rtoi(a + 0.5);
    endfunction

endpackage

// File: rtl/nco_phase_acc.sv
// Phase accumulator with its tuning-word register.
// The accumulator adds the tuning word every clock. The register is loaded
// from the control write port when the address matches TUNE_ADDR.
// Assumes: a retune changes the rate only and never the phase.
module nco_phase_acc #(
    parameter int PHASE_W   = 32,
    parameter int REG_AW    = 2,
    parameter int TUNE_ADDR = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [REG_AW-1:0]  cfg_addr,
    input  logic [PHASE_W-1:0] cfg_wdata,
    output logic [PHASE_W-1:0] phase
);
    localparam logic [REG_AW-1:0] TUNE_SEL = REG_AW'(TUNE_ADDR);

    logic [PHASE_W-1:0] acc_q;
    logic [PHASE_W-1:0] tune_q;

    // Advance the phase by the current tuning word every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_q + tune_q;
    end

    // Load the tuning word on a matching control write.
    always_ff @(posedge clk) begin
        if (!rst_n)                              tune_q <= '0;
        else if (cfg_we && cfg_addr == TUNE_SEL) tune_q <= cfg_wdata;
    end

    assign phase = acc_q;

    assert_foreign_write_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr != TUNE_SEL) |=> $stable(tune_q));

    assert_tune_loaded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == TUNE_SEL) |=> tune_q == $past(cfg_wdata));
endmodule

// File: rtl/nco_trig_lut.sv
// Registered sine/cosine lookup built from a quarter-wave table.
// The table holds QN+1 samples, 0..QN inclusive, so that the peak is stored.
// Cosine reads the same table QN steps ahead.
// Assumes: ADDR_W >= 3. Values are symmetric, so -AMP..AMP.
module nco_trig_lut #(
    parameter int ADDR_W = 10,
    parameter int TRIG_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        addr_in,
    output logic signed [TRIG_W-1:0] sin_out,
    output logic signed [TRIG_W-1:0] cos_out
);
    localparam int QN  = 2 ** (ADDR_W - 2);
    localparam int AMP = 2 ** (TRIG_W - 1) - 1;

    logic signed [TRIG_W-1:0] qtab  [QN+1];
    logic signed [TRIG_W-1:0] trig_q [2];

    // Quarter-wave samples, computed at elaboration.
    for (genvar k = 0; k <= QN; k++) begin : g_tab
        assign qtab[k] = TRIG_W'(nco_mix_pkg::quarter_sine(k, QN, AMP));
    end

    // Port 0 reads sine and port 1 reads cosine, a quarter cycle ahead.
    for (genvar p = 0; p < 2; p++) begin : g_port
        logic [ADDR_W-1:0]        a;
        logic [ADDR_W-2:0]        idx;
        logic signed [TRIG_W-1:0] val;

        assign a = (p == 0) ? addr_in : addr_in + ADDR_W'(QN);

        // Fold the quadrant onto the quarter table and apply the sign.
        always_comb begin
            idx = a[ADDR_W-2] ? (ADDR_W-1)'(QN) - {1'b0, a[ADDR_W-3:0]}
                              : {1'b0, a[ADDR_W-3:0]};
            val = a[ADDR_W-1] ? -qtab[idx] : qtab[idx];
        end

        // Register the looked-up value.
        always_ff @(posedge clk) begin
            if (!rst_n) trig_q[p] <= '0;
            else        trig_q[p] <= val;
        end
    end

    assign sin_out = trig_q[0];
    assign cos_out = trig_q[1];

    assert_zero_index_quadrature_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_in == '0) |=> (sin_out == '0 && cos_out == TRIG_W'(AMP)));

    assert_symmetric_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sin_out != {1'b1, {(TRIG_W-1){1'b0}}} && cos_out != {1'b1, {(TRIG_W-1){1'b0}}});
endmodule

// File: rtl/nco_round_mult.sv
// Signed multiply with round-half-up to O_W bits, registered.
// Half an output LSB is added before the low DROP bits are discarded.
// Assumes: A_W + B_W > O_W. The product of two symmetric operands fits O_W.
module nco_round_mult #(
    parameter int A_W = 14,
    parameter int B_W = 16,
    parameter int O_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en,
    input  logic signed [A_W-1:0] a,
    input  logic signed [B_W-1:0] b,
    output logic signed [O_W-1:0] res
);
    localparam int P_W  = A_W + B_W;
    localparam int DROP = P_W - O_W;

    logic signed [P_W-1:0] prod;
    logic signed [P_W:0]   sum;
    logic                  fits;

    // Form the full product and add half an output LSB.
    always_comb begin
        prod = a * b;
        sum  = {prod[P_W-1], prod} + (P_W+1)'(2 ** (DROP - 1));
        fits = (sum[P_W:DROP+O_W-1] == '0) || (&sum[P_W:DROP+O_W-1]);
    end

    // Keep the rounded upper bits when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)  res <= '0;
        else if (en) res <= sum[DROP+O_W-1:DROP];
    end

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> fits);
endmodule

// File: rtl/nco_iq_mixer.sv
// Tunable NCO quadrature down-mixer, the top level.
// The pipeline has three stages: capture the sample and phase index, look up
// the table, then multiply and round. out_valid trails in_valid by 3 cycles.
// Assumes: the oscillator runs every clock and samples may arrive with gaps.
module nco_iq_mixer #(
    parameter int SAMPLE_W  = 14,
    parameter int PHASE_W   = 32,
    parameter int ADDR_W    = 10,
    parameter int TRIG_W    = 16,
    parameter int OUT_W     = 16,
    parameter int REG_AW    = 2,
    parameter int TUNE_ADDR = 0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] in_sample,
    input  logic                       cfg_we,
    input  logic [REG_AW-1:0]          cfg_addr,
    input  logic [PHASE_W-1:0]         cfg_wdata,
    output logic                       out_valid,
    output logic signed [OUT_W-1:0]    out_i,
    output logic signed [OUT_W-1:0]    out_q
);
    logic [PHASE_W-1:0]         phase;
    logic                       v1_q, v2_q, v3_q;
    logic signed [SAMPLE_W-1:0] smp1_q, smp2_q;
    logic [ADDR_W-1:0]          idx1_q;
    logic signed [TRIG_W-1:0]   sin2, cos2;
    logic signed [TRIG_W-1:0]   trig2 [2];
    logic signed [OUT_W-1:0]    mix3 [2];

    nco_phase_acc #(.PHASE_W(PHASE_W), .REG_AW(REG_AW), .TUNE_ADDR(TUNE_ADDR)) u_acc (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .phase(phase)
    );

    // Stage 1: capture the sample and the phase index on a valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1_q   <= 1'b0;
            smp1_q <= '0;
            idx1_q <= '0;
        end else begin
            v1_q <= in_valid;
            if (in_valid) begin
                smp1_q <= in_sample;
                idx1_q <= phase[PHASE_W-1 -: ADDR_W];
            end
        end
    end

    nco_trig_lut #(.ADDR_W(ADDR_W), .TRIG_W(TRIG_W)) u_lut (
        .clk(clk), .rst_n(rst_n), .addr_in(idx1_q), .sin_out(sin2), .cos_out(cos2)
    );

    // Stage 2: align the sample and the strobe with the registered table output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v2_q   <= 1'b0;
            smp2_q <= '0;
        end else begin
            v2_q   <= v1_q;
            smp2_q <= smp1_q;
        end
    end

    assign trig2[0] = cos2;
    assign trig2[1] = sin2;

    // Stage 3: one rounding multiplier per branch, 0 for I and 1 for Q.
    for (genvar c = 0; c < 2; c++) begin : g_branch
        nco_round_mult #(.A_W(SAMPLE_W), .B_W(TRIG_W), .O_W(OUT_W)) u_mul (
            .clk(clk), .rst_n(rst_n), .en(v2_q), .a(smp2_q), .b(trig2[c]), .res(mix3[c])
        );
    end

    // Stage 3 strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) v3_q <= 1'b0;
        else        v3_q <= v2_q;
    end

    assign out_valid = v3_q;
    assign out_i     = mix3[0];
    assign out_q     = mix3[1];

    assert_valid_follows_stage_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(v2_q));

    assert_zero_sample_zero_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (v2_q && smp2_q == '0) |=> (out_i == '0 && out_q == '0));
endmodule

// File: tb/sim_nco_iq_mixer.sv
// Self-checking bench. An arithmetic model predicts the phase, the table and
// the rounding. Outputs are compared at the falling edge.
module sim_nco_iq_mixer;
    localparam real PI_B = 3.14159265358979;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic signed [13:0] in_sample = '0;
    logic               cfg_we = 1'b0;
    logic [1:0]         cfg_addr = '0;
    logic [31:0]        cfg_wdata = '0;
    logic               out_valid;
    logic signed [15:0] out_i, out_q;

    int    checks = 0;
    int    errors = 0;
    string tag = "R1";
    logic [31:0] m_acc = '0;
    logic [31:0] m_tune = '0;
    logic [2:0]  m_vd = '0;
    int    exp_i [$];
    int    exp_q [$];
    int    wd = 0;

    always #10 clk = ~clk;

    nco_iq_mixer u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    function automatic int tsin(int k);
        real v;
        v = 32767.0 * $sin(2.0 * PI_B * (k % 1024) / 1024.0);
        return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
    endfunction

    function automatic int rmix(int s, int t);
        longint p;
        p = longint'(s) * longint'(t) + 64'sd8192;
        return int'(p >>> 14);
    endfunction

    // Reference model: phase, tuning word, strobe delay and expected outputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_acc = '0; m_tune = '0; m_vd = '0;
            exp_i.delete(); exp_q.delete();
        end else begin
            if (in_valid) begin
                int k;
                k = int'(m_acc[31:22]);
                exp_i.push_back(rmix(int'(in_sample), tsin(k + 256)));
                exp_q.push_back(rmix(int'(in_sample), tsin(k)));
            end
            m_vd = {m_vd[1:0], in_valid};
            m_acc = m_acc + m_tune;
            if (cfg_we && cfg_addr == 2'd0) m_tune = cfg_wdata;
        end
    end

    // Compare the outputs against the model at the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (out_valid !== m_vd[2]) begin
                errors++;
                $display("FAIL R6 (%s) out_valid actual %0b expected %0b", tag, out_valid, m_vd[2]);
            end
            if (out_valid && exp_i.size() > 0) begin
                int ei, eq;
                ei = exp_i.pop_front(); eq = exp_q.pop_front();
                checks++;
                if (int'(out_i) != ei || int'(out_q) != eq) begin
                    errors++;
                    $display("FAIL %s I/Q actual %0d/%0d expected %0d/%0d", tag, out_i, out_q, ei, eq);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog actual %0d cycles expected completion", wd);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Drive n cycles. mode 0: ramp, 1: constant, 2: extremes, 3: gapped ramp.
    task automatic drive(input int n, input int mode, input int cval);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            case (mode)
                0: begin in_valid = 1'b1; in_sample = 14'((c * 37) % 16384 - 8192); end
                1: begin in_valid = 1'b1; in_sample = 14'(cval); end
                2: begin in_valid = 1'b1; in_sample = (c % 2 == 0) ? -14'sd8192 : 14'sd8191; end
                default: begin in_valid = (c % 3 != 1); in_sample = 14'(c * 113 - 3000); end
            endcase
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        tag = "R1";
        checks++;
        if (out_valid !== 1'b0 || out_i !== 16'sd0 || out_q !== 16'sd0) begin
            errors++;
            $display("FAIL R1 reset outputs actual %0b/%0d/%0d expected 0/0/0", out_valid, out_i, out_q);
        end
        @(negedge clk); rst_n = 1'b1;
        checks++;
        if (out_valid !== 1'b0 || out_i !== 16'sd0) begin
            errors++;
            $display("FAIL R1 after reset actual %0b/%0d expected 0/0", out_valid, out_i);
        end
        tag = "R9";
        drive(20, 1, 5000);
        tag = "R4";
        wr(2'd0, 32'h0040_0000);
        drive(1100, 0, 0);
        tag = "R8";
        drive(600, 2, 0);
        tag = "R3";
        wr(2'd0, 32'h1234_5679);
        drive(500, 0, 0);
        tag = "R2";
        wr(2'd1, 32'h0999_0000);
        wr(2'd3, 32'h7000_0001);
        drive(200, 0, 0);
        tag = "R7";
        wr(2'd0, 32'h0150_0003);
        drive(300, 3, 0);
        tag = "R6";
        drive(400, 3, 0);
        tag = "R5";
        drive(300, 1, -1);
        drive(300, 1, 1);
        repeat (6) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule